// File: doc/BRIEF.md
# Priority Pin Crossbar Allocator

This block places the digital signals of a set of on-chip peripherals onto a general-purpose pin array of three 8-bit ports, 24 pins in all. Software enables peripherals and marks pins to keep out of the pool through a small synchronous write port. The block then hands out pins every cycle without a clock in between. Signals are taken one at a time in a fixed priority order. Each one gets the lowest-numbered pin that is still free and not masked. The transmit/receive pair of the first UART is the exception: it always sits on two fixed pins.

For every signal the block reports which pin it won and whether it won one. For every pin it reports a select code that names the owning signal, or zero for plain GPIO. Pin data and output enable come from the owning signal, or from the port latch inputs when no signal owns the pin. Analog functions, pad behaviour and input synchronisers sit outside this block.

Top module: `pxb_crossbar`

## Requirements
- R1: After reset all configuration registers read as zero. No signal is valid, every pin carries select code 0, and every pin's data and output enable follow `gpio_dout`/`gpio_doe`.
- R2: A write with `cfg_wr_en` high loads the addressed register on the rising clock edge. Address 0 holds the peripheral enables: bit0 UART, bit1 SPI, bit2 two-wire bus (SDA/SCL), bit3 comparator output CP0, bit4 asynchronous comparator output CP0A, bit5 system clock output, bit6 counter external clock ECI, bit7 timer 0 input. Address 1 holds bits[1:0] as the number of counter compare outputs (0 to 3), bit2 as timer 1 enable and bit3 as SPI 4-wire mode. Addresses 2, 3 and 4 hold the skip masks of ports 0, 1 and 2.
- R3: Signals are placed in priority order, with index 0 the highest: TX0=0, RX0=1, SCK=2, MISO=3, MOSI=4, NSS=5, SDA=6, SCL=7, CP0=8, CP0A=9, SYSCLK=10, CEX0=11, CEX1=12, CEX2=13, ECI=14, T0=15, T1=16. Pin index is port*8+bit. Each enabled signal other than TX0/RX0 gets the lowest pin index that is neither masked nor held by a higher-priority signal. A disabled signal reports valid 0 and pin index 0.
- R4: With the UART enabled, TX0 sits on pin 4 and RX0 on pin 5, even when those pins are masked.
- R5: With the UART disabled, pins 4 and 5 are ordinary free pins for the other signals.
- R6: A pin whose skip-mask bit is 1 is never given to a greedily placed signal. It stays GPIO unless the UART pair is fixed on it.
- R7: NSS takes a pin only when SPI is enabled and 4-wire mode is set. Otherwise it consumes no pin.
- R8: The compare-output count N enables CEX0 to CEX(N-1) and no others.
- R9: An enabled signal that finds no free pin reports valid 0 and drives no pin.
- R10: A pin owned by signal index k carries select code k+1 and takes data and output enable from `sig_dout[k]`/`sig_doe[k]`. An unowned pin carries code 0 and takes `gpio_dout`/`gpio_doe`.
- R11: Writes to addresses 5, 6 and 7 change no register and so leave every allocation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 3 | Register address |
| cfg_wr_data | input | 8 | Register write data |
| sig_dout | input | 17 | Output data of each signal, by priority index |
| sig_doe | input | 17 | Output enable of each signal, by priority index |
| gpio_dout | input | 24 | Port latch data for each pin |
| gpio_doe | input | 24 | Port latch output enable for each pin |
| sig_pin_idx | output | 85 | 5-bit pin index per signal; signal k at bits [5k+4:5k] |
| sig_pin_vld | output | 17 | Signal holds a pin |
| pin_sel_code | output | 120 | 5-bit select code per pin; pin p at bits [5p+4:5p] |
| pin_dout | output | 24 | Data driven toward each pin |
| pin_doe | output | 24 | Output enable driven toward each pin |

## Verification
The first pattern enables the UART alone, which shows whether the fixed pair differs from greedy placement. The second enables SPI and the two-wire bus without the UART, which shows whether pins 4 and 5 go back to the pool and whether NSS stays silent in 3-wire mode. Next, a port 0 mask of 0x44 and then a mask over pins 4 and 5 under an active UART are applied. Together they separate skipping from ownership and show that the fixed pair overrides the mask. Compare-output counts, full enables over a nearly fully masked array, and per-pin data/enable patterns then expose counting faults, exhaustion and routing mix-ups.

// File: rtl/pxb_pkg.sv
package pxb_pkg;

   // signal priority indices (order is behaviour)
   localparam int SIG_N    = 17;
   localparam int S_TX     = 0;
   localparam int S_RX     = 1;
   localparam int S_SCK    = 2;
   localparam int S_MISO   = 3;
   localparam int S_MOSI   = 4;
   localparam int S_NSS    = 5;
   localparam int S_SDA    = 6;
   localparam int S_SCL    = 7;
   localparam int S_CP0    = 8;
   localparam int S_CP0A   = 9;
   localparam int S_SYSCLK = 10;
   localparam int S_CEX0   = 11;
   localparam int S_ECI    = 14;
   localparam int S_T0     = 15;
   localparam int S_T1     = 16;
   localparam int CEX_N    = 3;
   localparam int FIXED_N  = 2;   // leading signals on fixed pins

   // configuration register map
   localparam int REG_W       = 8;
   localparam int A_PERIPH    = 0;
   localparam int A_MISC      = 1;
   localparam int A_SKIP_BASE = 2;

   typedef struct packed {
      logic t0;
      logic eci;
      logic sysclk;
      logic cp0a;
      logic cp0;
      logic smb;
      logic spi;
      logic uart;
   } periph_en_t;

   typedef struct packed {
      logic       spi_4w;
      logic       t1;
      logic [1:0] cex_cnt;
   } misc_t;

endpackage

// File: rtl/pxb_cfg_regs.sv
module pxb_cfg_regs
   import pxb_pkg::*;
#(
   parameter int PORT_N = 3,
   parameter int PORT_W = 8,
   parameter int ADDR_W = 3,
   localparam int PIN_N = PORT_N * PORT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [SIG_N-1:0]  sig_req,
   output logic [PIN_N-1:0]  skip_mask
);

   localparam int MISC_W = $bits(misc_t);

   if (PORT_W > REG_W) begin : g_bad_port_w
      $error("pxb_cfg_regs: PORT_W wider than a register");
   end
   if (A_SKIP_BASE + PORT_N > (1 << ADDR_W)) begin : g_bad_addr_w
      $error("pxb_cfg_regs: ADDR_W too small for the skip masks");
   end

   periph_en_t periph_q;
   misc_t      misc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         periph_q <= '0;
         misc_q   <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(A_PERIPH)) periph_q <= periph_en_t'(wr_data);
         if (wr_addr == ADDR_W'(A_MISC))   misc_q   <= misc_t'(wr_data[MISC_W-1:0]);
      end
   end

   for (genvar p = 0; p < PORT_N; p++) begin : g_skip
      logic [PORT_W-1:0] mask_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask_q <= '0;
         else if (wr_en && wr_addr == ADDR_W'(A_SKIP_BASE + p))
            mask_q <= wr_data[PORT_W-1:0];
      end
      assign skip_mask[p*PORT_W +: PORT_W] = mask_q;

      assert_skip_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == ADDR_W'(A_SKIP_BASE + p))
         |=> skip_mask[p*PORT_W +: PORT_W] == $past(wr_data[PORT_W-1:0]));
   end

   // peripheral enables -> per-signal requests
   always_comb begin
      sig_req           = '0;
      sig_req[S_TX]     = periph_q.uart;
      sig_req[S_RX]     = periph_q.uart;
      sig_req[S_SCK]    = periph_q.spi;
      sig_req[S_MISO]   = periph_q.spi;
      sig_req[S_MOSI]   = periph_q.spi;
      sig_req[S_NSS]    = periph_q.spi & misc_q.spi_4w;
      sig_req[S_SDA]    = periph_q.smb;
      sig_req[S_SCL]    = periph_q.smb;
      sig_req[S_CP0]    = periph_q.cp0;
      sig_req[S_CP0A]   = periph_q.cp0a;
      sig_req[S_SYSCLK] = periph_q.sysclk;
      for (int c = 0; c < CEX_N; c++)
         sig_req[S_CEX0 + c] = (misc_q.cex_cnt > 2'(c));
      sig_req[S_ECI]    = periph_q.eci;
      sig_req[S_T0]     = periph_q.t0;
      sig_req[S_T1]     = misc_q.t1;
   end

   assert_nss_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sig_req[S_NSS] |-> (sig_req[S_SCK] && misc_q.spi_4w));

endmodule

// File: rtl/pxb_alloc.sv
module pxb_alloc
   import pxb_pkg::*;
#(
   parameter int PIN_N  = 24,
   parameter int TX_PIN = 4,
   parameter int RX_PIN = 5,
   localparam int PIN_W = $clog2(PIN_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SIG_N-1:0] sig_req,
   input  logic [PIN_N-1:0] skip_mask,
   output logic [PIN_N-1:0] sig_claim [SIG_N],
   output logic [PIN_W-1:0] sig_pin   [SIG_N],
   output logic [SIG_N-1:0] sig_ok
);

   if (TX_PIN >= PIN_N || RX_PIN >= PIN_N || TX_PIN == RX_PIN) begin : g_bad_fixed
      $error("pxb_alloc: fixed pins must be distinct and inside the array");
   end

   function automatic int fixed_pin(input int s);
      return (s == S_TX) ? TX_PIN : RX_PIN;
   endfunction

   // greedy chain: occupancy grows as each signal is placed
   always_comb begin
      logic [PIN_N-1:0] occ;
      occ = skip_mask;
      for (int s = 0; s < SIG_N; s++) begin
         sig_claim[s] = '0;
         sig_pin[s]   = '0;
         sig_ok[s]    = 1'b0;
         if (sig_req[s]) begin
            if (s < FIXED_N) begin
               sig_ok[s]    = 1'b1;
               sig_claim[s] = PIN_N'(1) << fixed_pin(s);
               sig_pin[s]   = PIN_W'(fixed_pin(s));
            end else begin
               for (int p = 0; p < PIN_N; p++) begin
                  if (!sig_ok[s] && !occ[p]) begin
                     sig_ok[s]    = 1'b1;
                     sig_claim[s] = PIN_N'(1) << p;
                     sig_pin[s]   = PIN_W'(p);
                  end
               end
            end
         end
         occ = occ | sig_claim[s];
      end
   end

   for (genvar s = 0; s < SIG_N; s++) begin : g_chk
      assert_idle_sig_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !sig_req[s] |-> (!sig_ok[s] && sig_claim[s] == '0));

      assert_one_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
         sig_ok[s] |-> ($countones(sig_claim[s]) == 1));

      if (s >= FIXED_N) begin : g_greedy
         assert_skip_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
            sig_ok[s] |-> ((sig_claim[s] & skip_mask) == '0));
      end else begin : g_fixed
         assert_uart_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
            sig_req[s] |-> (sig_ok[s] && sig_pin[s] == PIN_W'(fixed_pin(s))));
      end
   end

endmodule

// File: rtl/pxb_route.sv
module pxb_route
   import pxb_pkg::*;
#(
   parameter int PIN_N  = 24,
   localparam int SEL_W = $clog2(SIG_N + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIN_N-1:0] sig_claim [SIG_N],
   input  logic [SIG_N-1:0] sig_dout,
   input  logic [SIG_N-1:0] sig_doe,
   input  logic [PIN_N-1:0] gpio_dout,
   input  logic [PIN_N-1:0] gpio_doe,
   output logic [SEL_W-1:0] pin_sel [PIN_N],
   output logic [PIN_N-1:0] pin_dout,
   output logic [PIN_N-1:0] pin_doe
);

   for (genvar p = 0; p < PIN_N; p++) begin : g_pin
      logic [SIG_N-1:0] owners;
      logic [SEL_W-1:0] sel;
      logic             d;
      logic             oe;

      always_comb begin
         for (int s = 0; s < SIG_N; s++) owners[s] = sig_claim[s][p];
      end

      always_comb begin
         sel = '0;
         d   = gpio_dout[p];
         oe  = gpio_doe[p];
         for (int s = 0; s < SIG_N; s++) begin
            if (owners[s]) begin
               sel = SEL_W'(s + 1);
               d   = sig_dout[s];
               oe  = sig_doe[s];
            end
         end
      end

      assign pin_sel[p]  = sel;
      assign pin_dout[p] = d;
      assign pin_doe[p]  = oe;

      assert_single_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(owners));

      assert_gpio_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (pin_sel[p] == '0) |-> (pin_dout[p] == gpio_dout[p] && pin_doe[p] == gpio_doe[p]));
   end

endmodule

// File: rtl/pxb_crossbar.sv
module pxb_crossbar
   import pxb_pkg::*;
#(
   parameter int PORT_N = 3,
   parameter int PORT_W = 8,
   parameter int ADDR_W = 3,
   parameter int TX_PIN = 4,
   parameter int RX_PIN = 5,
   localparam int PIN_N = PORT_N * PORT_W,
   localparam int PIN_W = $clog2(PIN_N),
   localparam int SEL_W = $clog2(SIG_N + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_wr_en,
   input  logic [ADDR_W-1:0]      cfg_wr_addr,
   input  logic [REG_W-1:0]       cfg_wr_data,
   input  logic [SIG_N-1:0]       sig_dout,
   input  logic [SIG_N-1:0]       sig_doe,
   input  logic [PIN_N-1:0]       gpio_dout,
   input  logic [PIN_N-1:0]       gpio_doe,
   output logic [SIG_N*PIN_W-1:0] sig_pin_idx,
   output logic [SIG_N-1:0]       sig_pin_vld,
   output logic [PIN_N*SEL_W-1:0] pin_sel_code,
   output logic [PIN_N-1:0]       pin_dout,
   output logic [PIN_N-1:0]       pin_doe
);

   if (PORT_N < 1 || PORT_W < 1) begin : g_bad_shape
      $error("pxb_crossbar: empty pin array");
   end

   logic [SIG_N-1:0] sig_req;
   logic [PIN_N-1:0] skip_mask;
   logic [PIN_N-1:0] sig_claim [SIG_N];
   logic [PIN_W-1:0] sig_pin   [SIG_N];
   logic [SEL_W-1:0] pin_sel   [PIN_N];

   pxb_cfg_regs #(
      .PORT_N (PORT_N),
      .PORT_W (PORT_W),
      .ADDR_W (ADDR_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr_en),
      .wr_addr   (cfg_wr_addr),
      .wr_data   (cfg_wr_data),
      .sig_req   (sig_req),
      .skip_mask (skip_mask)
   );

   pxb_alloc #(
      .PIN_N  (PIN_N),
      .TX_PIN (TX_PIN),
      .RX_PIN (RX_PIN)
   ) u_alloc (
      .clk       (clk),
      .rst_n     (rst_n),
      .sig_req   (sig_req),
      .skip_mask (skip_mask),
      .sig_claim (sig_claim),
      .sig_pin   (sig_pin),
      .sig_ok    (sig_pin_vld)
   );

   pxb_route #(
      .PIN_N (PIN_N)
   ) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .sig_claim (sig_claim),
      .sig_dout  (sig_dout),
      .sig_doe   (sig_doe),
      .gpio_dout (gpio_dout),
      .gpio_doe  (gpio_doe),
      .pin_sel   (pin_sel),
      .pin_dout  (pin_dout),
      .pin_doe   (pin_doe)
   );

   for (genvar s = 0; s < SIG_N; s++) begin : g_sig_out
      assign sig_pin_idx[s*PIN_W +: PIN_W] = sig_pin[s];
   end
   for (genvar p = 0; p < PIN_N; p++) begin : g_pin_out
      assign pin_sel_code[p*SEL_W +: SEL_W] = pin_sel[p];
   end

   assert_reset_gpio_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (sig_pin_vld == '0 && pin_dout == gpio_dout && pin_doe == gpio_doe));

endmodule

// File: tb/pxb_crossbar_bench.sv
module pxb_crossbar_bench;

   localparam int NS = 17;
   localparam int NP = 24;
   localparam int PW = 5;
   localparam int SW = 5;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             wr_en;
   logic [2:0]       wr_addr;
   logic [7:0]       wr_data;
   logic [NS-1:0]    sig_dout, sig_doe;
   logic [NP-1:0]    gpio_dout, gpio_doe;
   logic [NS*PW-1:0] sig_pin_idx;
   logic [NS-1:0]    sig_pin_vld;
   logic [NP*SW-1:0] pin_sel_code;
   logic [NP-1:0]    pin_dout, pin_doe;

   always #4 clk = ~clk;   // 125 MHz

   pxb_crossbar u_pxb_crossbar (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_wr_en    (wr_en),
      .cfg_wr_addr  (wr_addr),
      .cfg_wr_data  (wr_data),
      .sig_dout     (sig_dout),
      .sig_doe      (sig_doe),
      .gpio_dout    (gpio_dout),
      .gpio_doe     (gpio_doe),
      .sig_pin_idx  (sig_pin_idx),
      .sig_pin_vld  (sig_pin_vld),
      .pin_sel_code (pin_sel_code),
      .pin_dout     (pin_dout),
      .pin_doe      (pin_doe)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   // shadow of the configuration, kept from the register map
   logic [7:0] sh_periph;
   logic [3:0] sh_misc;
   logic [7:0] sh_skip [3];

   int exp_pin  [NS];
   bit exp_ok   [NS];
   int exp_code [NP];

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int got_pin(input int s);
      return int'(sig_pin_idx[s*PW +: PW]);
   endfunction

   function automatic int got_code(input int p);
      return int'(pin_sel_code[p*SW +: SW]);
   endfunction

   task automatic build_model();
      bit [NS-1:0] rq;
      bit [NP-1:0] occ;
      rq     = '0;
      rq[0]  = sh_periph[0];
      rq[1]  = sh_periph[0];
      rq[2]  = sh_periph[1];
      rq[3]  = sh_periph[1];
      rq[4]  = sh_periph[1];
      rq[5]  = sh_periph[1] & sh_misc[3];
      rq[6]  = sh_periph[2];
      rq[7]  = sh_periph[2];
      rq[8]  = sh_periph[3];
      rq[9]  = sh_periph[4];
      rq[10] = sh_periph[5];
      rq[11] = (sh_misc[1:0] >= 2'd1);
      rq[12] = (sh_misc[1:0] >= 2'd2);
      rq[13] = (sh_misc[1:0] == 2'd3);
      rq[14] = sh_periph[6];
      rq[15] = sh_periph[7];
      rq[16] = sh_misc[2];
      occ = {sh_skip[2], sh_skip[1], sh_skip[0]};
      for (int p = 0; p < NP; p++) exp_code[p] = 0;
      for (int s = 0; s < NS; s++) begin
         exp_ok[s]  = 1'b0;
         exp_pin[s] = 0;
         if (rq[s]) begin
            if (s == 0) begin exp_ok[s] = 1'b1; exp_pin[s] = 4; end
            else if (s == 1) begin exp_ok[s] = 1'b1; exp_pin[s] = 5; end
            else begin
               for (int p = 0; p < NP; p++)
                  if (!exp_ok[s] && !occ[p]) begin exp_ok[s] = 1'b1; exp_pin[s] = p; end
            end
            if (exp_ok[s]) begin
               occ[exp_pin[s]]       = 1'b1;
               exp_code[exp_pin[s]]  = s + 1;
            end
         end
      end
   endtask

   task automatic verify_all(input string req);
      build_model();
      for (int s = 0; s < NS; s++) begin
         chk(req, $sformatf("valid of signal %0d", s), int'(sig_pin_vld[s]), int'(exp_ok[s]));
         chk(req, $sformatf("pin of signal %0d", s), got_pin(s), exp_pin[s]);
      end
      for (int p = 0; p < NP; p++)
         chk(req, $sformatf("select code of pin %0d", p), got_code(p), exp_code[p]);
   endtask

   task automatic cfg_write(input int addr, input int data);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 3'(addr);
      wr_data = 8'(data);
      @(negedge clk);
      wr_en = 1'b0;
      case (addr)
         0: sh_periph  = 8'(data);
         1: sh_misc    = 4'(data);
         2: sh_skip[0] = 8'(data);
         3: sh_skip[1] = 8'(data);
         4: sh_skip[2] = 8'(data);
         default: ;
      endcase
      #1;
   endtask

   task automatic clear_shadow();
      sh_periph = '0;
      sh_misc   = '0;
      for (int i = 0; i < 3; i++) sh_skip[i] = '0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      gpio_dout = 24'h5A3C96;
      gpio_doe  = 24'hC3A50F;
      #1;
      verify_all("R1");
      chk("R1", "pin_dout after reset", int'(pin_dout), int'(gpio_dout));
      chk("R1", "pin_doe after reset", int'(pin_doe), int'(gpio_doe));
   endtask

   task automatic t_uart_only();
      cfg_write(0, 8'h01);
      chk("R4", "TX0 pin", got_pin(0), 4);
      chk("R4", "RX0 pin", got_pin(1), 5);
      verify_all("R4");
   endtask

   task automatic t_spi_smb_no_uart();
      cfg_write(0, 8'h06);
      chk("R5", "SCL takes pin 4", got_pin(7), 4);
      chk("R5", "pin 5 unowned", got_code(5), 0);
      chk("R7", "NSS idle in 3-wire", int'(sig_pin_vld[5]), 0);
      verify_all("R3");
   endtask

   task automatic t_skip_mask();
      cfg_write(1, 8'h08);
      cfg_write(0, 8'h07);
      cfg_write(2, 8'h44);
      chk("R6", "MOSI pin", got_pin(4), 3);
      chk("R7", "NSS pin in 4-wire", got_pin(5), 7);
      chk("R6", "SDA pin", got_pin(6), 8);
      chk("R6", "SCL pin", got_pin(7), 9);
      chk("R6", "pin 2 left GPIO", got_code(2), 0);
      chk("R6", "pin 6 left GPIO", got_code(6), 0);
      verify_all("R6");
   endtask

   task automatic t_uart_over_mask();
      cfg_write(2, 8'h30);
      chk("R4", "TX0 on masked pin 4", got_pin(0), 4);
      chk("R4", "RX0 on masked pin 5", got_code(5), 2);
      verify_all("R4");
      cfg_write(2, 8'h00);
   endtask

   task automatic t_cex_count();
      cfg_write(0, 8'h00);
      cfg_write(1, 8'h02);
      chk("R8", "CEX0 pin", got_pin(11), 0);
      chk("R8", "CEX1 pin", got_pin(12), 1);
      chk("R8", "CEX2 idle", int'(sig_pin_vld[13]), 0);
      verify_all("R2/R8");
      cfg_write(1, 8'h03);
      chk("R8", "CEX2 pin", got_pin(13), 2);
      verify_all("R8");
      cfg_write(1, 8'h04);
      chk("R2", "T1 alone on pin 0", got_pin(16), 0);
      verify_all("R2");
   endtask

   task automatic t_exhaust();
      cfg_write(1, 8'h0F);
      cfg_write(3, 8'hFF);
      cfg_write(4, 8'hFF);
      cfg_write(0, 8'hFF);
      chk("R9", "SCL holds last free pin", got_pin(7), 7);
      chk("R9", "CP0 has no pin", int'(sig_pin_vld[8]), 0);
      chk("R9", "T1 has no pin", int'(sig_pin_vld[16]), 0);
      verify_all("R9");
      cfg_write(4, 8'hFE);
      chk("R9", "CP0 takes pin 16", got_pin(8), 16);
      chk("R9", "CP0A still without pin", int'(sig_pin_vld[9]), 0);
      verify_all("R9");
   endtask

   task automatic t_route();
      sig_dout  = 17'h1A5C3;
      sig_doe   = 17'h0F0F0;
      gpio_dout = 24'hA5A5A5;
      gpio_doe  = 24'h3C3C3C;
      #1;
      build_model();
      for (int p = 0; p < NP; p++) begin
         int ed, eo;
         if (exp_code[p] == 0) begin ed = int'(gpio_dout[p]); eo = int'(gpio_doe[p]); end
         else begin ed = int'(sig_dout[exp_code[p]-1]); eo = int'(sig_doe[exp_code[p]-1]); end
         chk("R10", $sformatf("pin_dout[%0d]", p), int'(pin_dout[p]), ed);
         chk("R10", $sformatf("pin_doe[%0d]", p), int'(pin_doe[p]), eo);
      end
      sig_doe = ~sig_doe;
      #1;
      chk("R10", "pin 16 oe follows CP0", int'(pin_doe[16]), int'(sig_doe[8]));
   endtask

   task automatic t_unused_addr();
      cfg_write(5, 8'hFF);
      cfg_write(6, 8'h00);
      cfg_write(7, 8'hA5);
      verify_all("R11");
   endtask

   task automatic t_rereset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      clear_shadow();
      #1;
      verify_all("R1");
      chk("R1", "pin_dout after second reset", int'(pin_dout), int'(gpio_dout));
   endtask

   initial begin
      rst_n     = 1'b0;
      wr_en     = 1'b0;
      wr_addr   = '0;
      wr_data   = '0;
      sig_dout  = '0;
      sig_doe   = '0;
      gpio_dout = '0;
      gpio_doe  = '0;
      clear_shadow();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_uart_only();
      t_spi_smb_no_uart();
      t_skip_mask();
      t_uart_over_mask();
      t_cex_count();
      t_exhaust();
      t_route();
      t_unused_addr();
      t_rereset();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule